// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned WIDTH-bit operands into a 2*WIDTH-bit product using one adder and one accumulator register. The product takes WIDTH clock cycles to form. A single-cycle `start` in the idle state captures both operands. The multiplicand goes into a double-width register that moves one place left on each cycle. The multiplier goes into a register that moves right, so its lowest bit is the one in use on each cycle. A row of AND gates masks the shifted multiplicand with that bit. The adder adds the result into the accumulator, and the sum is written back in one parallel load.

A client pulses `start` while `busy` is low and then waits for the one-cycle `done` pulse. At that point `product` holds the result. It keeps that value until the next accepted start, which clears the accumulator. While the block is busy it ignores any further `start` and any change on the operand inputs. Area grows linearly with WIDTH, and latency is WIDTH cycles.

Top module: `seqmul_top`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `product` is 0.
- R2: A `start` sampled high while `busy` is 0 makes `busy` 1 on the next cycle and clears `product` to 0 on that same edge.
- R3: When `done` is 1, `product` equals the unsigned product of the `op_a` and `op_b` values captured by the accepted start.
- R4: After the accepting edge, `busy` stays 1 for exactly WIDTH cycles. `done` rises on the edge where `busy` falls.
- R5: `done` is high for exactly one cycle per multiplication.
- R6: A `start` sampled while `busy` is 1 is ignored. The result and the timing of the running multiplication are unchanged.
- R7: While `busy` is 0 and no start is accepted, `product` holds its value.
- R8: Changes on `op_a` and `op_b` while `busy` is 1 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a multiplication; taken only when idle |
| op_a | input | WIDTH | Multiplicand operand |
| op_b | input | WIDTH | Multiplier operand |
| busy | output | 1 | High while the iterations run |
| done | output | 1 | One-cycle pulse when the product is complete |
| product | output | 2*WIDTH | Accumulated product |

## Verification
Each internal fault shows up at the ports within one multiplication. A misstep of the iteration counter changes the length of the `busy` window, so `done` arrives a cycle early or late. A fault in the shift registers or the adder gives a wrong value on `product` in the cycle where `done` is high. If the multiplier register shifts in the wrong direction or uses the wrong bit, only some operand pairs give wrong results. For that reason every pair of operand values is swept in a 4-bit configuration. Each sweep also repeats the start request during the run and changes the operands during the run, which exposes any capture that is not properly gated.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    function automatic int unsigned cnt_bits(input int unsigned width);
        return (width < 2) ? 1 : $clog2(width);
    endfunction

endpackage

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl
    import seqmul_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int unsigned CW = cnt_bits(WIDTH);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    typedef struct packed {
        phase_e          phase;
        logic [CW-1:0]   cnt;
        logic            done;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_RUN;
                    st_d.cnt   = '0;
                end
            end
            PH_RUN: begin
                if (st_q.cnt == LAST) begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign load = start && (st_q.phase == PH_IDLE);
    assign step = (st_q.phase == PH_RUN);
    assign busy = (st_q.phase == PH_RUN);
    assign done = st_q.done;

endmodule

// File: rtl/seqmul_mcand_reg.sv
module seqmul_mcand_reg #(
    parameter int unsigned WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   din,
    output logic [2*WIDTH-1:0] dout
);
    localparam int unsigned PW = 2 * WIDTH;

    logic [PW-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d = {{WIDTH{1'b0}}, din};
        end else if (step) begin
            sh_d = {sh_q[PW-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign dout = sh_q;

endmodule

// File: rtl/seqmul_mplier_reg.sv
module seqmul_mplier_reg #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] din,
    output logic             cur_bit
);
    logic [WIDTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d = din;
        end else if (step) begin
            sh_d = {1'b0, sh_q[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign cur_bit = sh_q[0];

endmodule

// File: rtl/seqmul_accum.sv
module seqmul_accum #(
    parameter int unsigned WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               step,
    input  logic [2*WIDTH-1:0] mcand,
    input  logic               mbit,
    output logic [2*WIDTH-1:0] acc
);
    localparam int unsigned PW = 2 * WIDTH;

    logic [PW-1:0] part;
    logic [PW-1:0] sum;
    logic [PW-1:0] acc_d, acc_q;

    for (genvar g = 0; g < PW; g++) begin : g_and_row
        assign part[g] = mcand[g] & mbit;
    end

    assign sum = acc_q + part;

    always_comb begin
        acc_d = acc_q;
        if (clear) begin
            acc_d = '0;
        end else if (step) begin
            acc_d = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc = acc_q;

endmodule

// File: rtl/seqmul_top.sv
module seqmul_top #(
    parameter int unsigned WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);
    localparam int unsigned PW = 2 * WIDTH;

    logic          load;
    logic          step;
    logic          mbit;
    logic [PW-1:0] mcand;

    seqmul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    seqmul_mcand_reg #(.WIDTH(WIDTH)) u_mcand (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .step (step),
        .din  (op_a),
        .dout (mcand)
    );

    seqmul_mplier_reg #(.WIDTH(WIDTH)) u_mplier (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .step    (step),
        .din     (op_b),
        .cur_bit (mbit)
    );

    seqmul_accum #(.WIDTH(WIDTH)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .clear (load),
        .step  (step),
        .mcand (mcand),
        .mbit  (mbit),
        .acc   (product)
    );

endmodule

// File: rtl/seqmul_chk.sv
module seqmul_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [WIDTH-1:0]   op_a,
    input logic [WIDTH-1:0]   op_b,
    input logic               busy,
    input logic               done,
    input logic [2*WIDTH-1:0] product
);
    localparam int unsigned PW = 2 * WIDTH;
    localparam int unsigned BW = $clog2(WIDTH + 1);

    logic [BW-1:0]    run_len;
    logic [WIDTH-1:0] cap_a, cap_b;
    logic [PW-1:0]    want;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
            cap_a   <= '0;
            cap_b   <= '0;
        end else begin
            run_len <= busy ? run_len + 1'b1 : '0;
            if (start && !busy) begin
                cap_a <= op_a;
                cap_b <= op_b;
            end
        end
    end

    assign want = PW'(cap_a) * PW'(cap_b);

    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && product == '0));

    a_r3_product_value: assert property (@(posedge clk) disable iff (rst)
        done |-> (product == want));

    a_r4_busy_bounded: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < BW'(WIDTH)));

    a_r4_done_on_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && $past(run_len) == BW'(WIDTH - 1)));

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r5_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));

endmodule

bind seqmul_top seqmul_chk #(.WIDTH(WIDTH)) u_seqmul_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .op_a    (op_a),
    .op_b    (op_b),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/tb_seqmul_top.sv
`timescale 1ns/1ps
module tb_seqmul_top;
    localparam int unsigned W  = 4;
    localparam int unsigned PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic          busy;
    logic          done;
    logic [PW-1:0] product;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    seqmul_top #(.WIDTH(W)) dut (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .op_a    (op_a),
        .op_b    (op_b),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_one(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
        logic [PW-1:0] exp_p;
        exp_p = PW'(a) * PW'(b);
        @(negedge clk);
        start = 1'b1; op_a = a; op_b = b;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", 64'(busy), 64'd1);
        check("R2 product cleared", 64'(product), 64'd0);
        for (int k = 1; k < int'(W); k++) begin
            if (poke) begin
                op_a = ~a; op_b = b + 4'd5;
                start = (k == 1);
            end
            @(negedge clk);
            start = 1'b0;
            check("R4 busy held", 64'(busy), 64'd1);
            check("R6 no early done", 64'(done), 64'd0);
        end
        @(negedge clk);
        check("R4 done at WIDTH cycles", 64'(done), 64'd1);
        check("R4 busy cleared", 64'(busy), 64'd0);
        check(poke ? "R8 R6 R3 product" : "R3 product", 64'(product), 64'(exp_p));
        @(negedge clk);
        check("R5 done one cycle", 64'(done), 64'd0);
        check("R7 product hold", 64'(product), 64'(exp_p));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy reset", 64'(busy), 64'd0);
        check("R1 done reset", 64'(done), 64'd0);
        check("R1 product reset", 64'(product), 64'd0);

        run_one(4'd15, 4'd15, 1'b0);
        for (int i = 0; i < 3; i++) begin
            op_a = W'(i * 7); op_b = W'(i * 3 + 1);
            @(negedge clk);
            check("R7 idle hold", 64'(product), 64'd225);
        end

        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                run_one(W'(a), W'(b), ((a + b) % 2) == 1);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule